// File: doc/BRIEF.md
# Pad Input Capture and Output Drive Cell

This cell sits between one logic cell and one bidirectional pad. On its output side it picks one of several logic-cell outputs, optionally inverts it, and presents it with an enable to the pad's three-state driver. On its input side it takes the pad level and hands it back to the logic array either directly, through an edge-triggered register, or through a level-sensitive latch. The pad's analogue behaviour is modelled outside the cell: the cell gives the value and enable for the driver and receives the level seen at the pad.

The capture element uses a capture clock taken from one of two dedicated clock pins or from an array product term. An inversion control picks the sensing sense, so the register can capture on either edge and the latch can be open on either level. All three clock sources are treated as levels sampled by the system clock. A register capture happens at the first system-clock edge that sees the selected clock at its active level after it was inactive. Global reset clears the stored value.

Top module: `pin_io_cell`

## Requirements
- R1: `padOut` equals `lccOut[srcSel]` XOR `outInvert`, with no clock delay.
- R2: `padOe` equals `oeTerm`. A 1 drives the pad and a 0 leaves it high-impedance. The input path always reads `padIn`, so with the driver on it reads back the driven value, and with the driver off it reads the external level.
- R3: When `capMode` is 0 or 3 (bypass), `fbToArray` equals `padIn` in the same cycle.
- R4: When `capMode` is 1 (register), a system-clock edge stores `padIn` if it sees the effective capture level at 1 and the previous edge saw it at 0. `fbToArray` shows the stored value until the next such edge.
- R5: When `capMode` is 2 (latch), `fbToArray` follows `padIn` with no clock delay while the effective capture level is 1. While the level is 0, `fbToArray` holds the `padIn` value from the last system-clock edge at which the level was 1.
- R6: `clkSel` 0 picks `clkPin1`, 1 picks `clkPin2`, and 2 or 3 picks `termClk`. Activity on the clocks that are not selected has no effect on the stored value.
- R7: `clkInvert`=1 inverts the selected clock before use. The register then captures on the falling edge of the raw clock, and the latch is open while the raw clock is low.
- R8: `rstN`=0 clears the stored value to 0 at once. The edge tracker comes out of reset as if the clock were already active, so a capture clock that is high at reset release causes no capture until it has been low.
- R9: A `srcSel` value of `NUM_SRC` or above selects source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that samples all capture clocks |
| rstN | input | 1 | Global reset, asynchronous, active low |
| clkPin1 | input | 1 | Dedicated clock pin one |
| clkPin2 | input | 1 | Dedicated clock pin two |
| termClk | input | 1 | Clock from an array product term |
| clkSel | input | 2 | Capture clock source select |
| clkInvert | input | 1 | Capture clock polarity inversion |
| capMode | input | 2 | 0/3 bypass, 1 register, 2 latch |
| lccOut | input | NUM_SRC | Logic-cell outputs available for the pad |
| srcSel | input | $clog2(NUM_SRC) | Index of the driving logic-cell output |
| outInvert | input | 1 | Output polarity inversion |
| oeTerm | input | 1 | Output-enable term |
| padIn | input | 1 | Level seen at the pad |
| padOut | output | 1 | Value for the pad driver |
| padOe | output | 1 | Enable for the pad driver |
| fbToArray | output | 1 | Captured or direct pad value back to the array |

## Verification
The bench builds the cell with `NUM_SRC` set to 5. This gives a three-bit select that is not a power of two, so select codes 5 to 7 can occur and the fallback of R9 is exercised. The bench also models the pad itself, which lets it test readback with the driver on and sensing of an external level with the driver off. Random clock toggling across every source, polarity and capture mode, plus a reset in the middle of the run, covers the behaviour at reset release and when the configuration is switched while running.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;

  typedef enum logic [1:0] {
    CAP_BYPASS  = 2'd0,
    CAP_REG     = 2'd1,
    CAP_LATCH   = 2'd2,
    CAP_BYPASS2 = 2'd3
  } capMode_e;

  typedef enum logic [1:0] {
    CSRC_PIN1  = 2'd0,
    CSRC_PIN2  = 2'd1,
    CSRC_TERM  = 2'd2,
    CSRC_TERM2 = 2'd3
  } clkSrc_e;

  // strobes from capture control to the datapath
  typedef struct packed {
    logic loadNow;   // write padIn into the storage element this edge
    logic passThru;  // present padIn directly to the array
  } capStb_t;

endpackage

// File: rtl/io_cap_ctrl.sv
module io_cap_ctrl
  import pin_io_pkg::*;
(
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       clkPin1,
  input  logic       clkPin2,
  input  logic       termClk,
  input  logic [1:0] clkSel,
  input  logic       clkInvert,
  input  capMode_e   capMode,
  output capStb_t    stb
);

  localparam int NUM_CLK_SRC = 4;

  logic [NUM_CLK_SRC-1:0] srcVec;
  logic capLvl;
  logic prevLvl;
  logic riseSeen;

  assign srcVec = {termClk, termClk, clkPin2, clkPin1};
  assign capLvl = srcVec[clkSel] ^ clkInvert;

  // tracker leaves reset as "already active": no capture on a high clock at release
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b1;
    else       prevLvl <= capLvl;
  end

  assign riseSeen = capLvl & ~prevLvl;

  always_comb begin
    stb = '0;
    unique case (capMode)
      CAP_REG:   stb.loadNow = riseSeen;
      CAP_LATCH: begin
        stb.loadNow  = capLvl;
        stb.passThru = capLvl;
      end
      default:   stb.passThru = 1'b1;
    endcase
  end

  // R4
  rise_single_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    riseSeen |=> !riseSeen);

  // R6
  no_edge_when_quiet_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (clkSel == 2'd0 && $stable(clkSel) && $stable(clkPin1) && $stable(clkInvert))
      |-> !riseSeen);

endmodule

// File: rtl/io_cell_dp.sv
module io_cell_dp
  import pin_io_pkg::*;
#(
  parameter  int NUM_SRC = 8,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               sysClk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] lccOut,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               outInvert,
  input  logic               oeTerm,
  input  logic               padIn,
  input  capStb_t            stb,
  output logic               padOut,
  output logic               padOe,
  output logic               fbToArray
);

  localparam bit FULL_DECODE = ((1 << SEL_W) == NUM_SRC);

  logic srcBit;
  logic storeQ;

  generate
    if (FULL_DECODE) begin : g_fullSel
      assign srcBit = lccOut[srcSel];
    end else begin : g_guardSel
      assign srcBit = (int'(srcSel) < NUM_SRC) ? lccOut[srcSel] : lccOut[0];
    end
  endgenerate

  assign padOut = srcBit ^ outInvert;
  assign padOe  = oeTerm;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)            storeQ <= 1'b0;
    else if (stb.loadNow) storeQ <= padIn;
  end

  assign fbToArray = stb.passThru ? padIn : storeQ;

  // R8
  reset_clear_chk: assert property (@(posedge sysClk)
    !rstN |-> (storeQ == 1'b0));

  // R4 R5
  capture_hold_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    ($past(rstN) && $past(stb.loadNow) && !stb.passThru && !stb.loadNow)
      |-> (fbToArray == $past(padIn)));

  // R1
  polarity_flip_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    ($stable(lccOut) && $stable(srcSel) && !$stable(outInvert))
      |-> (padOut != $past(padOut)));

endmodule

// File: rtl/pin_io_cell.sv
module pin_io_cell
  import pin_io_pkg::*;
#(
  parameter  int NUM_SRC = 8,
  localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               sysClk,
  input  logic               rstN,
  input  logic               clkPin1,
  input  logic               clkPin2,
  input  logic               termClk,
  input  logic [1:0]         clkSel,
  input  logic               clkInvert,
  input  logic [1:0]         capMode,
  input  logic [NUM_SRC-1:0] lccOut,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               outInvert,
  input  logic               oeTerm,
  input  logic               padIn,
  output logic               padOut,
  output logic               padOe,
  output logic               fbToArray
);

  capStb_t capStb;

  io_cap_ctrl i_ctrl (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .clkPin1   (clkPin1),
    .clkPin2   (clkPin2),
    .termClk   (termClk),
    .clkSel    (clkSel),
    .clkInvert (clkInvert),
    .capMode   (capMode_e'(capMode)),
    .stb       (capStb)
  );

  io_cell_dp #(.NUM_SRC(NUM_SRC)) i_dp (
    .sysClk    (sysClk),
    .rstN      (rstN),
    .lccOut    (lccOut),
    .srcSel    (srcSel),
    .outInvert (outInvert),
    .oeTerm    (oeTerm),
    .padIn     (padIn),
    .stb       (capStb),
    .padOut    (padOut),
    .padOe     (padOe),
    .fbToArray (fbToArray)
  );

  // R3
  bypass_follow_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (capMode == 2'd0 || capMode == 2'd3) |-> (fbToArray == padIn));

endmodule

// File: tb/test_pin_io_cell.sv
module test_pin_io_cell;

  localparam int PERIOD = 10;
  localparam int NSRC   = 5;
  localparam int SW     = 3;

  logic sysClk = 1'b0;
  always #(PERIOD/2) sysClk = ~sysClk;

  logic            rstN;
  logic            clkPin1, clkPin2, termClk;
  logic [1:0]      clkSel;
  logic            clkInvert;
  logic [1:0]      capMode;
  logic [NSRC-1:0] lccOut;
  logic [SW-1:0]   srcSel;
  logic            outInvert, oeTerm;
  logic            extVal;
  logic            padIn, padOut, padOe, fbToArray;

  // pad model: driven level when enabled, external level otherwise
  assign padIn = padOe ? padOut : extVal;

  pin_io_cell #(.NUM_SRC(NSRC)) i_pin_io_cell (
    .sysClk(sysClk), .rstN(rstN), .clkPin1(clkPin1), .clkPin2(clkPin2),
    .termClk(termClk), .clkSel(clkSel), .clkInvert(clkInvert),
    .capMode(capMode), .lccOut(lccOut), .srcSel(srcSel),
    .outInvert(outInvert), .oeTerm(oeTerm), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbToArray(fbToArray)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic mStore, mPrev;

  function automatic logic mLvl();
    logic raw;
    case (clkSel)
      2'd0:    raw = clkPin1;
      2'd1:    raw = clkPin2;
      default: raw = termClk;
    endcase
    return raw ^ clkInvert;
  endfunction

  function automatic logic mLoad();
    if (capMode == 2'd1) return mLvl() && !mPrev;
    if (capMode == 2'd2) return mLvl();
    return 1'b0;
  endfunction

  function automatic logic expFb();
    if (capMode == 2'd0 || capMode == 2'd3) return padIn;
    if (capMode == 2'd2 && mLvl()) return padIn;
    return mStore;
  endfunction

  function automatic logic expPad();
    int idx;
    idx = int'(srcSel);
    if (idx >= NSRC) idx = 0;
    return lccOut[idx] ^ outInvert;
  endfunction

  function automatic string tagFor();
    if (capMode == 2'd1) return "R4";
    if (capMode == 2'd2) return "R5";
    return "R3";
  endfunction

  always @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      mStore <= 1'b0;
      mPrev  <= 1'b1;
    end else begin
      if (mLoad()) mStore <= padIn;
      mPrev <= mLvl();
    end
  end

  always @(negedge sysClk) begin
    if (rstN) begin
      chk(tagFor(), fbToArray, expFb(), "fbToArray vs model");
      chk("R1", padOut, expPad(), "padOut vs model");
      chk("R2", padOe, oeTerm, "padOe vs oeTerm");
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge sysClk);
      #1;
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; clkPin1 = 1'b1; clkPin2 = 1'b0; termClk = 1'b0;
    clkSel = 2'd0; clkInvert = 1'b0; capMode = 2'd1;
    lccOut = '0; srcSel = '0; outInvert = 1'b0; oeTerm = 1'b0; extVal = 1'b1;
    tick(3);
    @(negedge sysClk);
    chk("R8", fbToArray, 1'b0, "stored value during reset");
    tick(1);
    rstN = 1'b1;
    tick(2);
    @(negedge sysClk);
    chk("R8", fbToArray, 1'b0, "clock high at release, no capture");
    tick(1);
    clkPin1 = 1'b0;
    tick(1);
    clkPin1 = 1'b1;
    tick(1);
    @(negedge sysClk);
    chk("R4", fbToArray, 1'b1, "capture on rising edge");

    // R6: unselected clocks ignored
    tick(1);
    clkSel = 2'd1; extVal = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      clkPin1 = ~clkPin1;
      termClk = ~termClk;
    end
    tick(1);
    @(negedge sysClk);
    chk("R6", fbToArray, 1'b1, "unselected clocks toggled");

    // R7: inverted polarity captures on raw falling edge
    tick(1);
    extVal = 1'b1; clkInvert = 1'b1;
    tick(2);
    extVal = 1'b0; clkPin2 = 1'b1;
    tick(2);
    @(negedge sysClk);
    chk("R7", fbToArray, 1'b1, "raw rising edge ignored when inverted");
    tick(1);
    clkPin2 = 1'b0;
    tick(1);
    @(negedge sysClk);
    chk("R7", fbToArray, 1'b0, "raw falling edge captures when inverted");

    // R5: latch transparent then holding
    tick(1);
    capMode = 2'd2; clkSel = 2'd2; clkInvert = 1'b0; termClk = 1'b1; extVal = 1'b1;
    @(negedge sysClk);
    chk("R5", fbToArray, 1'b1, "latch open follows pad");
    tick(1);
    extVal = 1'b0;
    @(negedge sysClk);
    chk("R5", fbToArray, 1'b0, "latch open follows pad change");
    tick(1);
    extVal = 1'b1;
    tick(1);
    termClk = 1'b0; extVal = 1'b0;
    @(negedge sysClk);
    chk("R5", fbToArray, 1'b1, "latch closed holds");
    tick(2);
    @(negedge sysClk);
    chk("R5", fbToArray, 1'b1, "latch closed still holds");

    // R9: out-of-range select falls back to source 0
    tick(1);
    capMode = 2'd0; oeTerm = 1'b1; lccOut = 5'b11110; srcSel = 3'd6; outInvert = 1'b0;
    @(negedge sysClk);
    chk("R9", padOut, 1'b0, "select 6 uses source 0");
    tick(1);
    outInvert = 1'b1;
    @(negedge sysClk);
    chk("R9", padOut, 1'b1, "select 6 inverted");
    tick(1);
    srcSel = 3'd3;
    @(negedge sysClk);
    chk("R1", padOut, 1'b0, "select 3 inverted");

    // R2: readback with driver on, external level with driver off
    chk("R2", fbToArray, 1'b0, "readback of driven value");
    tick(1);
    oeTerm = 1'b0; extVal = 1'b1;
    @(negedge sysClk);
    chk("R2", padOe, 1'b0, "driver off");
    chk("R2", fbToArray, 1'b1, "external level sensed");

    // random phase, compared to the model on every clock
    void'($urandom(32'h1c3d5e7f));
    for (int c = 0; c < 3000; c++) begin
      tick(1);
      clkPin1 = 1'($urandom()); clkPin2 = 1'($urandom()); termClk = 1'($urandom());
      extVal  = 1'($urandom()); oeTerm  = 1'($urandom());
      lccOut  = NSRC'($urandom()); srcSel = SW'($urandom());
      if (c % 40 == 0) begin
        capMode   = 2'($urandom());
        clkSel    = 2'($urandom());
        clkInvert = 1'($urandom());
        outInvert = 1'($urandom());
      end
      if (c == 1500) rstN = 1'b0;
      if (c == 1503) rstN = 1'b1;
    end
    tick(2);
    finishRun();
  end

endmodule